// File: doc/BRIEF.md
# ADC Result Formatter with Read-Order Interlock

This block sits between an analog-to-digital converter core and a CPU bus. Each time the converter signals completion, the block takes the 10-bit conversion word and packs it into two 8-bit read registers, a high byte and a low byte. A 2-bit format field chooses how the word is packed. The word can be left-aligned, right-aligned, left-aligned with the top bit inverted (a signed value about mid-scale), or cut down to its top eight bits.

In the three 10-bit formats, software reads the high byte first and the low byte second. Reading the high byte sets a lock, and while the lock is set no new result is stored. This means the two bytes a reader collects always come from the same conversion. Reading the low byte releases the lock. A result that arrives while the lock holds is dropped, and a sticky overrun flag records the loss. In the 8-bit format the lock plays no part and every result is stored. Both registers are always written in the same clock cycle.

Top module: `adcfmt_top`

## Requirements
- R1: A synchronous active-high reset clears both data registers, the lock and the overrun flag to zero.
- R2: Format 00 (left-aligned): the high byte becomes result bits 9..2, and the low byte becomes result bits 1..0 placed in low-byte bits 7..6, with bits 5..0 at zero.
- R3: Format 01 (right-aligned): the high byte becomes result bits 9..8 in high-byte bits 1..0, with bits 7..2 at zero, and the low byte becomes result bits 7..0.
- R4: Format 10 (signed): packing as in format 00, except that high-byte bit 7 holds the inverse of result bit 9.
- R5: Format 11 (8-bit): the low byte becomes result bits 9..2 and the high byte reads zero.
- R6: A high-byte read strobe in formats 00, 01 or 10 sets the lock. While the lock is set, a done strobe that arrives with the format field not equal to 11 is dropped and leaves both registers unchanged. A done strobe in the same cycle as the setting read is still stored.
- R7: A low-byte read strobe clears the lock. If high and low read strobes arrive together, the lock ends up set. A done strobe in the same cycle as the releasing low read is still dropped.
- R8: A dropped result sets a sticky overrun flag. A low-byte read clears the flag, except when a drop happens in that same cycle, in which case the flag stays set.
- R9: With the format field at 11, every done strobe is stored whatever the lock state, and a high-byte read does not set the lock.
- R10: A stored result appears in both registers together on the clock edge after the one that sampled the done strobe.
- R11: A change of the format field with no done strobe leaves both registers unchanged. The new format applies only to the next stored result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: conv_result is valid |
| conv_result | input | 10 | Conversion word from the converter core |
| fmt_mode | input | 2 | Packing format: 00 left, 01 right, 10 signed, 11 8-bit |
| rd_high | input | 1 | Strobe: CPU reads the high byte |
| rd_low | input | 1 | Strobe: CPU reads the low byte |
| data_high | output | 8 | High byte register |
| data_low | output | 8 | Low byte register |
| overrun | output | 1 | Sticky flag: a result was dropped |

## Verification
The assertions assume that every input is sampled on the rising clock edge. They also assume that the format field does not need to stay constant from one cycle to the next, because a drop is decided from the format value present in the same cycle as the done strobe. The stimulus changes every input only on the falling edge, and it also tests cases where several strobes arrive in one cycle: a done strobe with a high-byte read, a done strobe with a low-byte read while locked, and both read strobes together. That way the priority rules are covered without assuming any particular order of requests. It also changes the format between results and while a result is stored, so that reformatting of a stored value would be detected.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
  typedef enum logic [1:0] {
    FMT_LEFT   = 2'b00,
    FMT_RIGHT  = 2'b01,
    FMT_SIGNED = 2'b10,
    FMT_TRUNC  = 2'b11
  } fmt_e;
endpackage

// File: rtl/adcfmt_packer.sv
module adcfmt_packer #(
  parameter int RES_W = 10,
  parameter int REG_W = 8
) (
  input  logic [RES_W-1:0] res,
  input  logic [1:0]       mode,
  output logic [REG_W-1:0] hi,
  output logic [REG_W-1:0] lo
);
  import adcfmt_pkg::*;
  localparam int XTRA = RES_W - REG_W;

  logic [REG_W-1:0] top_bits;
  logic [REG_W-1:0] tail_left;
  logic [REG_W-1:0] head_right;
  logic [REG_W-1:0] tail_right;

  always_comb begin
    top_bits   = res[RES_W-1 -: REG_W];
    tail_left  = REG_W'(res[XTRA-1:0]) << (REG_W - XTRA);
    head_right = REG_W'(res >> REG_W);
    tail_right = res[REG_W-1:0];
  end

  always_comb begin
    hi = '0;
    lo = '0;
    case (fmt_e'(mode))
      FMT_LEFT: begin
        hi = top_bits;
        lo = tail_left;
      end
      FMT_RIGHT: begin
        hi = head_right;
        lo = tail_right;
      end
      FMT_SIGNED: begin
        hi = {~top_bits[REG_W-1], top_bits[REG_W-2:0]};
        lo = tail_left;
      end
      default: begin
        hi = '0;
        lo = top_bits;
      end
    endcase
  end
endmodule

// File: rtl/adcfmt_lock.sv
module adcfmt_lock (
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic tenbit,
  input  logic rd_high,
  input  logic rd_low,
  output logic accept,
  output logic locked,
  output logic overrun
);
  logic drop;

  always_comb begin
    drop   = done && locked && tenbit;
    accept = done && !drop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      locked  <= (locked && !rd_low) || (rd_high && tenbit);
      overrun <= (overrun && !rd_low) || drop;
    end
  end

  // R8
  drop_sets_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (done && locked && tenbit) |=> overrun);

  // R7
  low_read_frees_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_low && !rd_high) |=> !locked);

  // R9
  trunc_no_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (!tenbit && !locked && rd_high) |=> !locked);
endmodule

// File: rtl/adcfmt_top.sv
module adcfmt_top #(
  parameter int RES_W = 10,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic [1:0]       fmt_mode,
  input  logic             rd_high,
  input  logic             rd_low,
  output logic [REG_W-1:0] data_high,
  output logic [REG_W-1:0] data_low,
  output logic             overrun
);
  import adcfmt_pkg::*;

  logic             tenbit;
  logic             accept;
  logic             locked;
  logic [REG_W-1:0] pk_hi;
  logic [REG_W-1:0] pk_lo;

  assign tenbit = (fmt_e'(fmt_mode) != FMT_TRUNC);

  adcfmt_packer #(.RES_W(RES_W), .REG_W(REG_W)) u_packer (
    .res  (conv_result),
    .mode (fmt_mode),
    .hi   (pk_hi),
    .lo   (pk_lo)
  );

  adcfmt_lock u_lock (
    .clk     (clk),
    .rst     (rst),
    .done    (conv_done),
    .tenbit  (tenbit),
    .rd_high (rd_high),
    .rd_low  (rd_low),
    .accept  (accept),
    .locked  (locked),
    .overrun (overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_high <= '0;
      data_low  <= '0;
    end else if (accept) begin
      data_high <= pk_hi;
      data_low  <= pk_lo;
    end
  end

  // R6
  hold_while_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && tenbit) |=> ($stable(data_high) && $stable(data_low)));

  // R5
  trunc_high_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !tenbit) |=> (data_high == '0));

  // R3
  right_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !locked && fmt_e'(fmt_mode) == FMT_RIGHT)
      |=> (data_high >> (RES_W - REG_W)) == '0);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> ($stable(data_high) && $stable(data_low)));
endmodule

// File: tb/adcfmt_top_bench.sv
module adcfmt_top_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       conv_done;
  logic [9:0] conv_result;
  logic [1:0] fmt_mode;
  logic       rd_high;
  logic       rd_low;
  logic [7:0] data_high;
  logic [7:0] data_low;
  logic       overrun;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int m_hi, m_lo, m_lock, m_ovr;

  always #2.5 clk = ~clk;

  adcfmt_top u_adcfmt_top (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_result(conv_result),
    .fmt_mode(fmt_mode), .rd_high(rd_high), .rd_low(rd_low),
    .data_high(data_high), .data_low(data_low), .overrun(overrun)
  );

  task automatic model_step();
    int r, md;
    bit drop;
    r = conv_result;
    md = fmt_mode;
    if (rst) begin
      m_hi = 0; m_lo = 0; m_lock = 0; m_ovr = 0;
      return;
    end
    drop = conv_done && (m_lock != 0) && (md != 3);
    if (conv_done && !drop) begin
      case (md)
        0: begin m_hi = r / 4; m_lo = (r % 4) * 64; end
        1: begin m_hi = r / 256; m_lo = r % 256; end
        2: begin m_hi = (r / 4) ^ 128; m_lo = (r % 4) * 64; end
        default: begin m_hi = 0; m_lo = r / 4; end
      endcase
    end
    m_ovr  = ((m_ovr != 0 && !rd_low) || drop) ? 1 : 0;
    m_lock = ((m_lock != 0 && !rd_low) || (rd_high && md != 3)) ? 1 : 0;
  endtask

  task automatic cyc(input bit r, input bit d, input int res, input int md,
                     input bit rh, input bit rl, input string tag);
    rst = r; conv_done = d; conv_result = 10'(res); fmt_mode = 2'(md);
    rd_high = rh; rd_low = rl;
    @(posedge clk);
    model_step();
    @(negedge clk);
    n_cmp++;
    if (data_high !== 8'(m_hi) || data_low !== 8'(m_lo) || overrun !== 1'(m_ovr)) begin
      n_bad++;
      $display("FAIL %s: hi=%h lo=%h ovr=%b expected hi=%h lo=%h ovr=%0d",
               tag, data_high, data_low, overrun, 8'(m_hi), 8'(m_lo), m_ovr);
    end
  endtask

  task automatic idle(input int md, input string tag);
    cyc(0, 0, 0, md, 0, 0, tag);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_hi = 0; m_lo = 0; m_lock = 0; m_ovr = 0;
    rst = 1; conv_done = 0; conv_result = 0; fmt_mode = 0; rd_high = 0; rd_low = 0;
    @(negedge clk);
    cyc(1, 1, 10'h3FF, 1, 1, 0, "R1");
    cyc(1, 0, 0, 0, 0, 0, "R1");

    // R2 left-aligned, R10 one-cycle latency
    cyc(0, 1, 10'h2D7, 0, 0, 0, "R2");
    cyc(0, 1, 10'h001, 0, 0, 0, "R10");
    cyc(0, 1, 10'h3FE, 0, 0, 0, "R2");
    // R3 right-aligned
    cyc(0, 1, 10'h2D7, 1, 0, 0, "R3");
    cyc(0, 1, 10'h1FF, 1, 0, 0, "R3");
    // R4 signed
    cyc(0, 1, 10'h200, 2, 0, 0, "R4");
    cyc(0, 1, 10'h1FF, 2, 0, 0, "R4");
    cyc(0, 1, 10'h3A5, 2, 0, 0, "R4");
    // R5 truncation
    cyc(0, 1, 10'h3A5, 3, 0, 0, "R5");
    cyc(0, 1, 10'h003, 3, 0, 0, "R5");
    // R11 mode change without new result
    cyc(0, 1, 10'h2C1, 1, 0, 0, "R11");
    idle(0, "R11"); idle(2, "R11"); idle(3, "R11");

    // R6 lock: done with rd_high stored, then drops
    cyc(0, 1, 10'h155, 0, 1, 0, "R6");
    cyc(0, 1, 10'h0AA, 0, 0, 0, "R6");
    cyc(0, 1, 10'h3C3, 1, 0, 0, "R8");
    idle(2, "R6");
    // R7 release: done in same cycle still dropped, overrun stays
    cyc(0, 1, 10'h111, 2, 0, 1, "R7");
    cyc(0, 0, 0, 0, 0, 1, "R8");
    cyc(0, 1, 10'h222, 0, 0, 0, "R7");
    // R7 both reads together: lock set wins
    cyc(0, 0, 0, 1, 1, 1, "R7");
    cyc(0, 1, 10'h333, 1, 0, 0, "R7");
    cyc(0, 0, 0, 1, 0, 1, "R8");
    // R9 truncation ignores lock, rd_high does not lock
    cyc(0, 0, 0, 0, 1, 0, "R9");
    cyc(0, 1, 10'h2F0, 3, 0, 0, "R9");
    cyc(0, 1, 10'h0F0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 1, "R9");
    cyc(0, 0, 0, 3, 1, 0, "R9");
    cyc(0, 1, 10'h1E1, 0, 0, 0, "R9");

    // sweep of values and formats with occasional reads
    for (int i = 0; i < 400; i++) begin
      cyc(0, (i % 3) != 1, (i * 97 + 13) % 1024, (i / 5) % 4,
          (i % 7) == 2, (i % 11) == 5, "R10");
    end
    // reset mid-run with lock and overrun set
    cyc(0, 0, 0, 0, 1, 0, "R1");
    cyc(0, 1, 10'h3FF, 0, 0, 0, "R1");
    cyc(1, 0, 0, 0, 0, 0, "R1");
    cyc(0, 1, 10'h0C3, 1, 0, 0, "R1");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule